// File: doc/BRIEF.md
# Baseband Transmit Port Sequencer

This block sequences the transmit side of a packet baseband modem, as seen from the medium access controller (MAC). A rising edge on the transmit enable starts a packet. The block first runs a fixed-length preamble/header phase, which is represented here by a symbol counter and a constant stub bit. It then raises its ready flag and pulls payload bits one at a time from the MAC on a bit clock that it generates itself. A chip strobe and a symbol strobe pace the spreader downstream. When the enable falls, the block finishes the symbol in progress. It then runs a tail of a fixed number of idle symbols, so that the power amplifier can ramp down. The ready flag drops only when the last chip of the last tail symbol has gone out.

Timing is counted in master clock cycles. A chip lasts `CHIP_DIV` cycles and a symbol lasts `CHIPS` chips, so `SYM = CHIP_DIV*CHIPS` cycles. The header always runs at one bit per symbol. The payload rate is `2^rate` bits per symbol, which gives a bit period of `SYM >> rate` cycles. `SYM` must be divisible by 8, and every bit period must be at least 2 cycles.

The payload path is a pull stream, and the MAC cannot apply back-pressure. After `ready_o` rises, the MAC must hold a valid bit on `tx_bit` before every active bit-clock edge, and may change it after that edge. A bit that is not presented in time is simply sampled as whatever value is on the pin. `tx_bit` is don't-care outside the data phase. The MAC sends each byte least significant bit first. The block handles single bits only and keeps no byte order of its own.

Top module: `bbtx_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the sequencer goes idle. From that edge on, `ready_o`, `bitclk_o`, `chip_stb_o`, `sym_stb_o` and `sp_bit_o` are all 0.
- R2: A 0-to-1 change of `tx_en` while idle starts a packet. Counting the first clock edge that samples `tx_en` high as edge 1, `ready_o` rises at edge `HDR_BITS*SYM+1`. It always rises at the end of a symbol.
- R3: While a packet is active, `chip_stb_o` is a one-cycle pulse every `CHIP_DIV` cycles. `sym_stb_o` is high only together with every `CHIPS`-th chip pulse. The header phase gives exactly `HDR_BITS*CHIPS` chip pulses and `HDR_BITS` symbol pulses.
- R4: In the data phase, `bitclk_o` has a period of `SYM >> rate` cycles, where `rate` is the `rate_sel` value (0..3). Outside the data phase `bitclk_o` is 0, and it is never high while `ready_o` is low.
- R5: With `clk_edge_sel`=0 the active edge is the 0-to-1 change of `bitclk_o`. With `clk_edge_sel`=1 the clock is inverted during the data phase and the active edge is the 1-to-0 change. In both cases the first active edge comes `(SYM>>rate)/2` cycles after the data phase begins.
- R6: On the clock edge where `bitclk_o` makes its active change, the value on `tx_bit` is captured and driven on `sp_bit_o` until the next capture. During the header phase `sp_bit_o` is 1.
- R7: `rate_sel` and `clk_edge_sel` are taken at the start of the packet. Changing them during the packet does not change the bit period.
- R8: After `tx_en` is sampled low, the data or header symbol in progress completes. If that sampling edge is itself a symbol end, one further data symbol runs. Exactly `TAIL_SYMS` tail symbols follow. During the tail, chip strobes continue and `bitclk_o` stays 0.
- R9: `ready_o` is still high in the cycle of the final chip pulse of the last tail symbol, and is low from the next cycle on.
- R10: A 0-to-1 change of `tx_en` while a packet is active is ignored. After the packet ends, the block stays idle until `tx_en` has gone low and risen again.
- R11: If `tx_en` falls during the header phase, `ready_o` never rises. The current header symbol completes, followed by `TAIL_SYMS` tail symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC; its edges start and stop a packet |
| rate_sel | input | 2 | Payload rate: 2^rate_sel bits per symbol |
| clk_edge_sel | input | 1 | 0: payload sampled on the rising bit-clock edge, 1: on the falling edge |
| tx_bit | input | 1 | Serial payload bit from the MAC |
| bitclk_o | output | 1 | Generated payload bit clock |
| ready_o | output | 1 | High from the end of the header until the last tail chip |
| chip_stb_o | output | 1 | One pulse per chip period toward the spreader |
| sym_stb_o | output | 1 | Pulse on the last chip of each symbol |
| sp_bit_o | output | 1 | Bit handed to the spreader (header stub or captured payload) |

## Verification
The stop request and the symbol boundary can land on the same clock edge. When that happens, the falling enable is sampled at exactly the edge that ends a symbol, and the boundary must not start the tail early. The bench provokes this at the fastest rate, where the last payload bit is sampled in the final cycle of a symbol, and drops the enable at that moment. It then expects the same four symbol pulses before `ready_o` falls as in the mid-symbol case. Every payload bit must also have been captured before the tail begins.

// File: rtl/bbtx_pkg.sv
`timescale 1ns/1ps
package bbtx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2,
    ST_TAIL = 2'd3
  } bbtx_state_t;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bbtx_timebase.sv
`timescale 1ns/1ps
// Chip and symbol pacing: runs only while a packet is active.
module bbtx_timebase #(
  parameter int CHIP_DIV = 8,
  parameter int CHIPS    = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic chip_stb,
  output logic sym_end
);
  localparam int SW = bbtx_pkg::cnt_width(CHIPS);
  localparam logic [SW-1:0] SLAST = SW'(CHIPS - 1);

  logic       chip_tick;
  logic [SW-1:0] ci;

  generate
    if (CHIP_DIV > 1) begin : g_div
      localparam int CW = bbtx_pkg::cnt_width(CHIP_DIV);
      localparam logic [CW-1:0] CLAST = CW'(CHIP_DIV - 1);
      logic [CW-1:0] cc;
      always_ff @(posedge clk) begin
        if (!rst_n || !run) cc <= '0;
        else if (cc == CLAST) cc <= '0;
        else cc <= cc + 1'b1;
      end
      assign chip_tick = run && (cc == CLAST);
    end else begin : g_nodiv
      assign chip_tick = run;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || !run) ci <= '0;
    else if (chip_tick) ci <= (ci == SLAST) ? '0 : ci + 1'b1;
  end

  assign chip_stb = chip_tick;
  assign sym_end  = chip_tick && (ci == SLAST);
endmodule

// File: rtl/bbtx_bitclk.sv
`timescale 1ns/1ps
// Payload bit clock and sampler for the data phase.
module bbtx_bitclk #(
  parameter int SYM_CYC = 88
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_data,
  input  logic [1:0] rate,
  input  logic       edge_sel,
  input  logic       tx_bit,
  output logic       bitclk,
  output logic       data_q
);
  localparam int PW = $clog2(SYM_CYC + 1);

  logic [PW-1:0] period, half, cyc;
  logic          sample;

  assign period = PW'(SYM_CYC) >> rate;
  assign half   = period >> 1;
  assign sample = in_data && (cyc == half - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || !in_data) cyc <= '0;
    else if (cyc == period - 1'b1) cyc <= '0;
    else cyc <= cyc + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= 1'b0;
    else if (sample) data_q <= tx_bit;
  end

  assign bitclk = in_data && ((cyc >= half) ^ edge_sel);
endmodule

// File: rtl/bbtx_ctrl.sv
`timescale 1ns/1ps
// Packet state machine: start on enable rise, stop after enable fall plus tail.
module bbtx_ctrl
  import bbtx_pkg::*;
#(
  parameter int HDR_BITS  = 192,
  parameter int TAIL_SYMS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic [1:0]  rate_sel,
  input  logic        edge_sel,
  input  logic        sym_end,
  output bbtx_state_t state,
  output logic [1:0]  rate_q,
  output logic        edge_q,
  output logic        ready
);
  localparam int HW = cnt_width(HDR_BITS);
  localparam int TW = cnt_width(TAIL_SYMS);
  localparam logic [HW-1:0] HLAST = HW'(HDR_BITS - 1);
  localparam logic [TW-1:0] TLAST = TW'(TAIL_SYMS - 1);

  logic          en_q, stop_q;
  logic [HW-1:0] hcnt;
  logic [TW-1:0] tcnt;
  logic          rise, fall;

  assign rise = tx_en && !en_q;
  assign fall = !tx_en && en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      en_q   <= 1'b0;
      stop_q <= 1'b0;
      ready  <= 1'b0;
      rate_q <= '0;
      edge_q <= 1'b0;
      hcnt   <= '0;
      tcnt   <= '0;
    end else begin
      en_q <= tx_en;
      case (state)
        ST_IDLE: if (rise) begin
          state  <= ST_HDR;
          rate_q <= rate_sel;
          edge_q <= edge_sel;
          stop_q <= 1'b0;
          hcnt   <= '0;
        end
        ST_HDR: begin
          if (fall) stop_q <= 1'b1;
          if (sym_end) begin
            if (stop_q) begin
              state <= ST_TAIL;
              tcnt  <= '0;
            end else if (hcnt == HLAST) begin
              state <= ST_DATA;
              ready <= 1'b1;
            end else begin
              hcnt <= hcnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (fall) stop_q <= 1'b1;
          if (sym_end && stop_q) begin
            state <= ST_TAIL;
            tcnt  <= '0;
          end
        end
        ST_TAIL: if (sym_end) begin
          if (tcnt == TLAST) begin
            state <= ST_IDLE;
            ready <= 1'b0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bbtx_sequencer.sv
`timescale 1ns/1ps
module bbtx_sequencer
  import bbtx_pkg::*;
#(
  parameter int CHIP_DIV  = 8,
  parameter int CHIPS     = 11,
  parameter int HDR_BITS  = 192,
  parameter int TAIL_SYMS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic [1:0] rate_sel,
  input  logic       clk_edge_sel,
  input  logic       tx_bit,
  output logic       bitclk_o,
  output logic       ready_o,
  output logic       chip_stb_o,
  output logic       sym_stb_o,
  output logic       sp_bit_o
);
  localparam int SYM_CYC = CHIP_DIV * CHIPS;

  bbtx_state_t state;
  logic [1:0]  rate_q;
  logic        edge_q, sym_end, data_q;

  bbtx_ctrl #(.HDR_BITS(HDR_BITS), .TAIL_SYMS(TAIL_SYMS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rate_sel(rate_sel),
    .edge_sel(clk_edge_sel), .sym_end(sym_end), .state(state),
    .rate_q(rate_q), .edge_q(edge_q), .ready(ready_o)
  );

  bbtx_timebase #(.CHIP_DIV(CHIP_DIV), .CHIPS(CHIPS)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE),
    .chip_stb(chip_stb_o), .sym_end(sym_end)
  );

  bbtx_bitclk #(.SYM_CYC(SYM_CYC)) u_bclk (
    .clk(clk), .rst_n(rst_n), .in_data(state == ST_DATA), .rate(rate_q),
    .edge_sel(edge_q), .tx_bit(tx_bit), .bitclk(bitclk_o), .data_q(data_q)
  );

  assign sym_stb_o = sym_end;

  always_comb begin
    case (state)
      ST_HDR:           sp_bit_o = 1'b1;
      ST_DATA, ST_TAIL: sp_bit_o = data_q;
      default:          sp_bit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bbtx_sequencer_chk.sv
`timescale 1ns/1ps
module bbtx_sequencer_chk (
  input logic clk,
  input logic rst_n,
  input logic ready_o,
  input logic bitclk_o,
  input logic chip_stb_o,
  input logic sym_stb_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (!ready_o && !bitclk_o && !chip_stb_o && !sym_stb_o));

  p_sym_on_chip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sym_stb_o |-> chip_stb_o);

  p_chip_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb_o |=> !chip_stb_o);

  p_ready_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(sym_stb_o));

  p_bitclk_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bitclk_o |-> ready_o);

  p_ready_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready_o) |-> $past(sym_stb_o));
endmodule

bind bbtx_sequencer bbtx_sequencer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .bitclk_o(bitclk_o),
  .chip_stb_o(chip_stb_o), .sym_stb_o(sym_stb_o)
);

// File: tb/sim_bbtx_sequencer.sv
`timescale 1ns/1ps
module sim_bbtx_sequencer;
  localparam int CD = 4, NC = 4, HB = 3, TS = 3;
  localparam int SYM = CD * NC;

  logic clk = 1'b0, rst_n = 1'b0, tx_en = 1'b0, tx_bit = 1'b0, clk_edge_sel = 1'b0;
  logic [1:0] rate_sel = 2'd0;
  logic bitclk_o, ready_o, chip_stb_o, sym_stb_o, sp_bit_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  bbtx_sequencer #(.CHIP_DIV(CD), .CHIPS(NC), .HDR_BITS(HB), .TAIL_SYMS(TS)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rate_sel(rate_sel),
    .clk_edge_sel(clk_edge_sel), .tx_bit(tx_bit), .bitclk_o(bitclk_o),
    .ready_o(ready_o), .chip_stb_o(chip_stb_o), .sym_stb_o(sym_stb_o),
    .sp_bit_o(sp_bit_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Start a packet and check the header phase (R2, R3, R6).
  task automatic start_pkt(input int rate, input bit sel);
    int n = 0, chips = 0, syms = 0;
    @(negedge clk);
    rate_sel = 2'(rate); clk_edge_sel = sel; tx_en = 1'b1;
    while (n < 1000) begin
      @(negedge clk); n++;
      if (ready_o) break;
      if (chip_stb_o) chips++;
      if (sym_stb_o) syms++;
      if (n == 2) chk(sp_bit_o == 1'b1, "R6 header stub bit", sp_bit_o, 1);
    end
    chk(n == HB * SYM + 1, "R2 ready latency", n, HB * SYM + 1);
    chk(chips == HB * NC, "R3 header chip count", chips, HB * NC);
    chk(syms == HB, "R3 header symbol count", syms, HB);
  endtask

  // Feed payload bits, check captures and bit period (R4..R7), then drop tx_en.
  task automatic data_phase(input int rate, input bit sel, input int nbits,
                            input logic [31:0] pat, input bit change_cfg);
    int bp = SYM >> rate;
    int cyc = 0, idx = 0, last = -1;
    logic act = sel ? 1'b0 : 1'b1;
    logic prev = bitclk_o;
    tx_bit = pat[0];
    while (idx < nbits && cyc < 4000) begin
      @(negedge clk); cyc++;
      if (bitclk_o == act && prev != act) begin
        chk(sp_bit_o == pat[idx], "R6 captured bit", sp_bit_o, pat[idx]);
        if (last < 0) chk(cyc == bp / 2, "R5 first active edge", cyc, bp / 2);
        else chk(cyc - last == bp, change_cfg ? "R7 period kept" : "R4 bit period",
                 cyc - last, bp);
        last = cyc; idx++;
        if (idx == 1 && change_cfg) begin
          rate_sel = 2'(rate ^ 2); clk_edge_sel = ~sel;
        end
        if (idx < nbits) tx_bit = pat[idx];
        else tx_en = 1'b0;
      end
      prev = bitclk_o;
    end
    chk(idx == nbits, "R4 active edges seen", idx, nbits);
  endtask

  // Tail after the drop (R8, R9); optionally raise tx_en inside the tail (R10).
  task automatic tail_phase(input bit raise);
    int nsym = 0, nchip = 0, badclk = 0;
    logic rdy_last = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (nsym >= 1 && chip_stb_o) nchip++;
      if (nsym >= 1 && bitclk_o) badclk++;
      if (sym_stb_o) begin
        nsym++;
        if (nsym == 1 + TS) rdy_last = ready_o;
        if (raise && nsym == 2) tx_en = 1'b1;
      end
      if (!ready_o) break;
    end
    chk(nsym == 1 + TS, "R8 symbols after drop", nsym, 1 + TS);
    chk(nchip == TS * NC, "R8 tail chips", nchip, TS * NC);
    chk(badclk == 0, "R8 bit clock quiet in tail", badclk, 0);
    chk(rdy_last == 1'b1, "R9 ready on final chip", rdy_last, 1);
    chk(ready_o == 1'b0, "R9 ready low after final chip", ready_o, 0);
  endtask

  task automatic t_reset_state;
    rst_n = 1'b0; tx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk({ready_o, bitclk_o, chip_stb_o, sym_stb_o, sp_bit_o} == 5'b0, "R1 reset outputs",
        {ready_o, bitclk_o, chip_stb_o, sym_stb_o, sp_bit_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(chip_stb_o == 1'b0 && ready_o == 1'b0, "R1 idle after release", chip_stb_o, 0);
  endtask

  task automatic t_rate0;
    start_pkt(0, 1'b0); data_phase(0, 1'b0, 2, 32'h2, 1'b0); tail_phase(1'b0);
  endtask

  task automatic t_boundary_drop;  // R8 collision: drop on a symbol-end edge
    start_pkt(3, 1'b0); data_phase(3, 1'b0, 16, 32'hA5C3, 1'b0); tail_phase(1'b0);
  endtask

  task automatic t_inverted_edge;
    start_pkt(1, 1'b1); data_phase(1, 1'b1, 3, 32'h5, 1'b0); tail_phase(1'b0);
  endtask

  task automatic t_cfg_latch;
    start_pkt(2, 1'b0); data_phase(2, 1'b0, 5, 32'h16, 1'b1); tail_phase(1'b0);
  endtask

  task automatic t_busy_rise;
    int chips = 0, rdy = 0;
    start_pkt(2, 1'b0); data_phase(2, 1'b0, 4, 32'h9, 1'b0); tail_phase(1'b1);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (chip_stb_o) chips++;
      if (ready_o) rdy++;
    end
    chk(chips == 0, "R10 no restart chips", chips, 0);
    chk(rdy == 0, "R10 no restart ready", rdy, 0);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    start_pkt(0, 1'b0); data_phase(0, 1'b0, 1, 32'h1, 1'b0); tail_phase(1'b0);
  endtask

  task automatic t_hdr_abort;
    int syms = 0, rdy = 0;
    @(negedge clk);
    rate_sel = 2'd0; clk_edge_sel = 1'b0; tx_en = 1'b1;
    repeat (20) @(negedge clk);
    tx_en = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sym_stb_o) syms++;
      if (ready_o) rdy++;
    end
    chk(rdy == 0, "R11 ready never rises", rdy, 0);
    chk(syms == 1 + TS, "R11 symbols after abort", syms, 1 + TS);
    chk(chip_stb_o == 1'b0, "R11 idle after tail", chip_stb_o, 0);
  endtask

  task automatic t_mid_reset;
    int chips = 0;
    @(negedge clk);
    rate_sel = 2'd1; tx_en = 1'b1;
    repeat (HB * SYM + 8) @(negedge clk);
    chk(ready_o == 1'b1, "R2 packet running before reset", ready_o, 1);
    rst_n = 1'b0; tx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk({ready_o, bitclk_o, chip_stb_o, sym_stb_o, sp_bit_o} == 5'b0, "R1 reset mid packet",
        {ready_o, bitclk_o, chip_stb_o, sym_stb_o, sp_bit_o}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (chip_stb_o) chips++;
    end
    chk(chips == 0, "R1 stays idle after reset", chips, 0);
  endtask

  initial begin
    t_reset_state();
    t_rate0();
    t_boundary_drop();
    t_inverted_edge();
    t_cfg_latch();
    t_busy_rise();
    t_hdr_abort();
    t_mid_reset();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule